// File: doc/BRIEF.md
# Processor Halt and Reset Arbiter

This block sits between a processor core, its configuration bits and a single-wire debug front end, and decides once per clock whether the core keeps running, stops in debug halt, or receives a system reset. Fault events arrive from the pipeline with a class code. A separate flag says whether the core is already servicing an exception. A fault that arrives while that flag is high is a fault-on-fault. It is handled at once, with no wait for an instruction boundary, and it ranks above every other halt source.

Two reset-disable bits choose, per fault class, between a reset and a debug halt. One bit covers address and bus faults, and it also governs fault-on-fault. The other bit covers illegal-instruction and privilege faults. Both bits clear gives the default response, which is a reset. A debug "background" command stops a running core. If the core is in a low-power state, the command first wakes the core and then stops it. A debug "go" command releases the halt. While the core is halted, a 3-bit cause field reports why.

All outputs are registered, so a decision appears one clock after the inputs that caused it. Every port is a plain control or status level or pulse. There is no streamed data, and so there is no valid/ready handshake.

Top module: `halt_reset_arbiter`

## Requirements
- R1: While rst_n is low and in the first cycle after it goes high, halt_req, reset_req, resume_pulse and wake_req are 0 and halt_cause is 0.
- R2: If fault_valid is high while exc_active is high and the core is not halted, and rd_addr_bus is 1, then on the next cycle halt_req is 1 and halt_cause is 1 (fault-on-fault). This holds for any value of fault_kind or rd_illegal.
- R3: If fault_valid is high while exc_active is high and the core is not halted, and rd_addr_bus is 0, then on the next cycle reset_req is 1 for exactly one cycle and halt_req stays 0.
- R4: A fault without exc_active has a class given by fault_kind: 0 illegal, 1 privilege, 2 address, 3 bus. Kinds 0 and 1 follow rd_illegal, and kinds 2 and 3 follow rd_addr_bus. When the selected bit is 1, the next cycle shows halt_req with halt_cause 3. When it is 0, the next cycle shows a one-cycle reset_req.
- R5: When several sources arrive in the same cycle, the winner is fixed: fault-on-fault first, then any other fault, then the background command. A reset chosen by the winner suppresses any halt in that cycle.
- R6: If dbg_bkgd is high while the core runs and core_sleep is low, then on the next cycle halt_req is 1 and halt_cause is 2.
- R7: If dbg_bkgd is high while the core runs and core_sleep is high, then wake_req is 1 for one cycle on the next cycle. On the cycle after that, halt_req is 1 and halt_cause is 2.
- R8: If dbg_go is high while halt_req is 1, then on the next cycle halt_req is 0, halt_cause is 0 and resume_pulse is 1 for exactly one cycle.
- R9: dbg_go has no effect while halt_req is 0: resume_pulse stays 0 and the other outputs do not change.
- R10: While halted and without dbg_go, halt_cause keeps its value and halt_req stays 1. Faults and background commands in this state are ignored.
- R11: Whenever reset_req is 1, halt_req is 0 and halt_cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | A fault event this cycle |
| fault_kind | input | 2 | Fault class: 0 illegal, 1 privilege, 2 address, 3 bus |
| exc_active | input | 1 | Exception processing is under way |
| rd_addr_bus | input | 1 | Reset-disable for address/bus faults and fault-on-fault |
| rd_illegal | input | 1 | Reset-disable for illegal/privilege faults |
| dbg_bkgd | input | 1 | Background (halt) command from debug front end |
| dbg_go | input | 1 | Go (resume) command from debug front end |
| core_sleep | input | 1 | Core is in a low-power state |
| halt_req | output | 1 | Core is held in debug halt |
| reset_req | output | 1 | One-cycle system reset request |
| resume_pulse | output | 1 | One-cycle resume indication after go |
| wake_req | output | 1 | One-cycle wake request to a sleeping core |
| halt_cause | output | 3 | 0 none, 1 fault-on-fault, 2 background, 3 fault with halt selected |

## Verification
A corrupted halted flag shows up as one of two errors. halt_req may drop without a go command, or a go command may fail to produce a resume pulse. Either error appears on the first cycle after the go command is presented. A corrupted cause register makes halt_cause change during a halt, or leaves it nonzero beside a reset request, and this is visible one cycle later. A lost wake-pending flag shows as a wake_req that no halt follows, which is exposed two cycles after the background command. A wrong class decode shows as a reset in place of a halt, or the reverse, on the cycle after the fault.

// File: rtl/hra_pkg.sv
package hra_pkg;
  localparam int KIND_W  = 2;
  localparam int CAUSE_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_ILLEGAL = 2'd0,
    K_PRIV    = 2'd1,
    K_ADDR    = 2'd2,
    K_BUS     = 2'd3
  } fault_kind_e;

  typedef enum logic [CAUSE_W-1:0] {
    C_NONE  = 3'd0,
    C_FOF   = 3'd1,
    C_BKGD  = 3'd2,
    C_FAULT = 3'd3
  } cause_e;
endpackage

// File: rtl/hra_classify.sv
module hra_classify
  import hra_pkg::*;
(
  input  logic              fault_valid,
  input  logic [KIND_W-1:0] fault_kind,
  input  logic              exc_active,
  input  logic              rd_addr_bus,
  input  logic              rd_illegal,
  output logic              flt_any,
  output logic              flt_halt,
  output cause_e            flt_cause
);
  logic is_fof;
  logic addr_class;

  always_comb begin
    is_fof     = fault_valid && exc_active;
    addr_class = (fault_kind == K_ADDR) || (fault_kind == K_BUS);
    flt_any    = fault_valid;
    if (is_fof) begin
      flt_halt  = rd_addr_bus;
      flt_cause = C_FOF;
    end else begin
      flt_halt  = addr_class ? rd_addr_bus : rd_illegal;
      flt_cause = C_FAULT;
    end
  end
endmodule

// File: rtl/hra_ctrl.sv
module hra_ctrl
  import hra_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flt_any,
  input  logic               flt_halt,
  input  cause_e             flt_cause,
  input  logic               dbg_bkgd,
  input  logic               dbg_go,
  input  logic               core_sleep,
  output logic               halt_req,
  output logic               reset_req,
  output logic               resume_pulse,
  output logic               wake_req,
  output logic [CAUSE_W-1:0] halt_cause
);
  logic   halted_q, halted_d;
  cause_e cause_q, cause_d;
  logic   rst_q, rst_d, res_q, res_d, wake_q, wake_d, pend_q, pend_d;

  always_comb begin
    halted_d = halted_q;
    cause_d  = cause_q;
    pend_d   = pend_q;
    rst_d    = 1'b0;
    res_d    = 1'b0;
    wake_d   = 1'b0;
    if (halted_q) begin
      if (dbg_go) begin
        halted_d = 1'b0;
        cause_d  = C_NONE;
        res_d    = 1'b1;
      end
    end else if (flt_any) begin
      pend_d = 1'b0;
      if (flt_halt) begin
        halted_d = 1'b1;
        cause_d  = flt_cause;
      end else begin
        rst_d   = 1'b1;
        cause_d = C_NONE;
      end
    end else if (pend_q) begin
      pend_d   = 1'b0;
      halted_d = 1'b1;
      cause_d  = C_BKGD;
    end else if (dbg_bkgd) begin
      if (core_sleep) begin
        wake_d = 1'b1;
        pend_d = 1'b1;
      end else begin
        halted_d = 1'b1;
        cause_d  = C_BKGD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      cause_q  <= C_NONE;
      rst_q    <= 1'b0;
      res_q    <= 1'b0;
      wake_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      halted_q <= halted_d;
      cause_q  <= cause_d;
      rst_q    <= rst_d;
      res_q    <= res_d;
      wake_q   <= wake_d;
      pend_q   <= pend_d;
    end
  end

  assign halt_req     = halted_q;
  assign reset_req    = rst_q;
  assign resume_pulse = res_q;
  assign wake_req     = wake_q;
  assign halt_cause   = cause_q;

  a_r7_wake_then_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> (halt_req || reset_req));
  a_r8_go_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && dbg_go) |=> (!halt_req && resume_pulse && halt_cause == C_NONE));
  a_r9_resume_only_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> $past(halt_req));
  a_r10_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !dbg_go) |=> (halt_req && $stable(halt_cause)));
  a_r11_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (!halt_req && halt_cause == C_NONE));
endmodule

// File: rtl/halt_reset_arbiter.sv
module halt_reset_arbiter
  import hra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_valid,
  input  logic [KIND_W-1:0] fault_kind,
  input  logic              exc_active,
  input  logic              rd_addr_bus,
  input  logic              rd_illegal,
  input  logic              dbg_bkgd,
  input  logic              dbg_go,
  input  logic              core_sleep,
  output logic              halt_req,
  output logic              reset_req,
  output logic              resume_pulse,
  output logic              wake_req,
  output logic [CAUSE_W-1:0] halt_cause
);
  logic   flt_any, flt_halt;
  cause_e flt_cause;

  hra_classify u_cls (
    .fault_valid (fault_valid),
    .fault_kind  (fault_kind),
    .exc_active  (exc_active),
    .rd_addr_bus (rd_addr_bus),
    .rd_illegal  (rd_illegal),
    .flt_any     (flt_any),
    .flt_halt    (flt_halt),
    .flt_cause   (flt_cause)
  );

  hra_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .flt_any      (flt_any),
    .flt_halt     (flt_halt),
    .flt_cause    (flt_cause),
    .dbg_bkgd     (dbg_bkgd),
    .dbg_go       (dbg_go),
    .core_sleep   (core_sleep),
    .halt_req     (halt_req),
    .reset_req    (reset_req),
    .resume_pulse (resume_pulse),
    .wake_req     (wake_req),
    .halt_cause   (halt_cause)
  );

  a_r2_fof_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && fault_valid && exc_active && rd_addr_bus) |=> (halt_req && halt_cause == C_FOF));
  a_r3_fof_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && fault_valid && exc_active && !rd_addr_bus) |=> (reset_req && !halt_req));
  a_r6_bkgd_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && !wake_req && !fault_valid && dbg_bkgd && !core_sleep) |=> (halt_req && halt_cause == C_BKGD));
endmodule

// File: tb/tb_halt_reset_arbiter.sv
module tb_halt_reset_arbiter;
  logic clk = 1'b0;
  logic rst_n;
  logic fault_valid, exc_active, rd_addr_bus, rd_illegal, dbg_bkgd, dbg_go, core_sleep;
  logic [1:0] fault_kind;
  logic halt_req, reset_req, resume_pulse, wake_req;
  logic [2:0] halt_cause;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  halt_reset_arbiter dut (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_kind(fault_kind),
    .exc_active(exc_active), .rd_addr_bus(rd_addr_bus), .rd_illegal(rd_illegal),
    .dbg_bkgd(dbg_bkgd), .dbg_go(dbg_go), .core_sleep(core_sleep),
    .halt_req(halt_req), .reset_req(reset_req), .resume_pulse(resume_pulse),
    .wake_req(wake_req), .halt_cause(halt_cause)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // packed view: {halt, reset, resume, wake, cause}
  function automatic int outs();
    return {halt_req, reset_req, resume_pulse, wake_req, halt_cause};
  endfunction

  function automatic int pk(input bit h, input bit r, input bit rs, input bit w, input int c);
    return {h, r, rs, w, c[2:0]};
  endfunction

  task automatic idle();
    fault_valid = 0; fault_kind = 0; exc_active = 0; dbg_bkgd = 0; dbg_go = 0; core_sleep = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic go_back();
    dbg_go = 1; step();
    step();
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); rd_addr_bus = 0; rd_illegal = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", outs(), 0);
    rst_n = 1; @(negedge clk);
    chk("R1 after reset", outs(), 0);
  endtask

  task automatic t_fof_halt();
    rd_addr_bus = 1; rd_illegal = 0;
    fault_valid = 1; exc_active = 1; fault_kind = 0; step();
    chk("R2 fof halt", outs(), pk(1,0,0,0,1));
    step();
    chk("R10 cause held", outs(), pk(1,0,0,0,1));
    fault_valid = 1; fault_kind = 3; dbg_bkgd = 1; step();
    chk("R10 sources ignored", outs(), pk(1,0,0,0,1));
    dbg_go = 1; step();
    chk("R8 go resume", outs(), pk(0,0,1,0,0));
    step();
    chk("R8 resume one cycle", outs(), 0);
  endtask

  task automatic t_fof_reset();
    rd_addr_bus = 0; rd_illegal = 1;
    fault_valid = 1; exc_active = 1; fault_kind = 1; step();
    chk("R3 fof reset", outs(), pk(0,1,0,0,0));
    step();
    chk("R3 reset one cycle", outs(), 0);
  endtask

  task automatic t_classes();
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 2; b++) begin
        bit sel;
        if (k >= 2) begin rd_addr_bus = b[0]; rd_illegal = ~b[0]; end
        else        begin rd_illegal = b[0]; rd_addr_bus = ~b[0]; end
        sel = b[0];
        fault_valid = 1; fault_kind = k[1:0]; step();
        if (sel) begin
          chk("R4 class halt", outs(), pk(1,0,0,0,3));
          go_back();
        end else begin
          chk("R4 class reset", outs(), pk(0,1,0,0,0));
          step();
        end
      end
    end
  endtask

  task automatic t_prio();
    rd_addr_bus = 1; rd_illegal = 1;
    fault_valid = 1; exc_active = 1; dbg_bkgd = 1; step();
    chk("R5 fof beats bkgd", outs(), pk(1,0,0,0,1));
    go_back();
    fault_valid = 1; fault_kind = 2; dbg_bkgd = 1; step();
    chk("R5 fault beats bkgd", outs(), pk(1,0,0,0,3));
    go_back();
    rd_addr_bus = 0;
    fault_valid = 1; fault_kind = 0; exc_active = 1; dbg_bkgd = 1; step();
    chk("R5 R11 reset beats halt", outs(), pk(0,1,0,0,0));
    step();
    chk("R5 no late halt", outs(), 0);
  endtask

  task automatic t_bkgd_run();
    dbg_bkgd = 1; step();
    chk("R6 bkgd halt", outs(), pk(1,0,0,0,2));
    go_back();
  endtask

  task automatic t_bkgd_sleep();
    dbg_bkgd = 1; core_sleep = 1; step();
    chk("R7 wake first", outs(), pk(0,0,0,1,0));
    step();
    chk("R7 then halt", outs(), pk(1,0,0,0,2));
    go_back();
  endtask

  task automatic t_go_idle();
    dbg_go = 1; step();
    chk("R9 go ignored", outs(), 0);
    step();
    chk("R9 still idle", outs(), 0);
  endtask

  initial begin
    t_reset();
    t_fof_halt();
    t_fof_reset();
    t_classes();
    t_prio();
    t_bkgd_run();
    t_bkgd_sleep();
    t_go_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #40000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule